// File: doc/BRIEF.md
# Peak Current Mode Slave PWM Leg

This block drives one leg of a bridge whose on-time ends each cycle when the switch current reaches its limit. An up-counting time base runs from zero to a programmed period and then wraps. A synchronization pulse from an upstream master timer restarts the counter at a fixed phase value, and the same pulse is passed on unchanged to timers further down the chain. Two outputs are set and cleared by matches of the counter against two compare values. Both outputs are also cleared whenever the counter sits at zero or at its period.

An external analog comparator signals that the current limit has been reached. Its level is brought into the clock domain and reduced to rising edges. Edges that fall inside a blanking window, placed a programmable distance after counter zero, are dropped, which hides the switching spike that follows each transition. A qualified edge restarts the counter exactly as a sync pulse does. In trip mode it also holds output B low until the next period begins. In sync-only mode, used when the leg drives synchronous rectifier switches, the edge only realigns the time base and leaves both outputs alone. Only the first qualified edge in a period is acted on.

All timing values are shadowed: the period, both compare values and both blanking values are copied from their inputs into working registers only while the counter is at zero.

Top module: `pcm_slave_pwm`

## Requirements
- R1: The counter advances by one each clock from zero up to the working period value and wraps to zero on the next clock; output timing follows this count.
- R2: syncOut equals syncIn in the same cycle, and a high syncIn on a clock edge loads the counter with PHASE_VAL (default 0) instead of advancing it.
- R3: Output A is registered: it goes high the cycle after the count equals compare A, and low the cycle after the count equals compare B, zero or the period; when a clear and the set coincide, the clear wins.
- R4: Output B is registered: it goes high the cycle after the count equals compare B, and low the cycle after the count equals compare A, zero or the period; when a clear and the set coincide, the clear wins.
- R5: Under reset both outputs are low and the working values are period RST_PERIOD, compare A RST_PERIOD+10 (past the period, so it never matches), compare B 20, blanking offset 2 and blanking length 4.
- R6: The working period, compare values and blanking values take their input values only on a clock edge where the count is zero; a change at any other time has no effect until the next count of zero.
- R7: compLevel passes through two synchronizing flops and then an edge detector; a low-to-high change of compLevel made between two clock edges is evaluated against the count on the third following edge.
- R8: A comparator edge evaluated while the count lies in the window from the blanking offset up to, but not including, offset plus length is discarded.
- R9: A qualified comparator edge loads the counter with PHASE_VAL on the edge where it is evaluated.
- R10: In trip mode (modeSyncOnly low) a qualified edge forces output B low from the next cycle and leaves output A unchanged for that cycle; B stays forced low until a clock edge on which the count equals the period or syncIn is high.
- R11: In sync-only mode (modeSyncOnly high) a qualified edge causes no output action; B follows its compare events as normal.
- R12: After a qualified edge, further comparator edges are discarded until a clock edge on which the count equals the period or syncIn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Restart pulse from the upstream timer |
| compLevel | input | 1 | Current-limit comparator level, asynchronous |
| modeSyncOnly | input | 1 | 1: comparator edge only realigns the counter; 0: it also trips output B |
| periodIn | input | CNT_W | Period value, counter runs 0 to this value |
| cmpAIn | input | CNT_W | Compare A value |
| cmpBIn | input | CNT_W | Compare B value |
| blankOffset | input | CNT_W | Count at which the blanking window opens |
| blankLength | input | CNT_W | Number of counts the blanking window lasts |
| outA | output | 1 | Leg output A |
| outB | output | 1 | Leg output B |
| syncOut | output | 1 | Copy of syncIn for downstream timers |

## Verification
The bench builds the block with an 8-bit counter and a reset period of 39, so a full period lasts forty clocks and the block wraps hundreds of times within the run, while random periods of 20 to 60 still leave room for compare values beyond the period. With the narrow counter the blanking boundary at counts 5 and 6, the one-event-per-period rule, the shadow reload at a later zero and the trip release by wrap or sync all fall within a few dozen cycles of a directed sync pulse. A cycle model built from the requirements is compared with both outputs and the sync pass-through on every clock during directed and random traffic.

// File: rtl/pcm_slave_pkg.sv
package pcm_slave_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;   // load counter with phase value
    logic reload;    // copy shadow inputs into working registers
  } dpCmd_t;

  // Status from datapath to control
  typedef struct packed {
    logic atZero;
    logic atPeriod;
    logic hitA;
    logic hitB;
    logic inBlank;
  } dpStat_t;

endpackage

// File: rtl/pcm_slave_datapath.sv
module pcm_slave_datapath
  import pcm_slave_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PHASE_VAL  = 0,
  parameter int RST_PERIOD = 199,
  parameter int RST_CMPA   = RST_PERIOD + 10,
  parameter int RST_CMPB   = 20,
  parameter int RST_OFFSET = 2,
  parameter int RST_LENGTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] cmpAIn,
  input  logic [CNT_W-1:0] cmpBIn,
  input  logic [CNT_W-1:0] blankOffset,
  input  logic [CNT_W-1:0] blankLength,
  output dpStat_t          stat,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] periodAct
);

  localparam int NUM_SHADOW = 5;
  localparam int SH_PRD = 0;
  localparam int SH_CA  = 1;
  localparam int SH_CB  = 2;
  localparam int SH_OFF = 3;
  localparam int SH_LEN = 4;
  localparam logic [CNT_W-1:0] PHASE_C = CNT_W'(PHASE_VAL);
  localparam logic [CNT_W-1:0] RST_VALS [NUM_SHADOW] = '{
    CNT_W'(RST_PERIOD), CNT_W'(RST_CMPA), CNT_W'(RST_CMPB),
    CNT_W'(RST_OFFSET), CNT_W'(RST_LENGTH)
  };

  logic [CNT_W-1:0] shadowIn  [NUM_SHADOW];
  logic [CNT_W-1:0] shadowAct [NUM_SHADOW];

  assign shadowIn[SH_PRD] = periodIn;
  assign shadowIn[SH_CA]  = cmpAIn;
  assign shadowIn[SH_CB]  = cmpBIn;
  assign shadowIn[SH_OFF] = blankOffset;
  assign shadowIn[SH_LEN] = blankLength;

  // Working copies, loaded only when the counter is at zero
  for (genvar s = 0; s < NUM_SHADOW; s++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          shadowAct[s] <= RST_VALS[s];
      else if (cmd.reload) shadowAct[s] <= shadowIn[s];
    end
  end

  assign periodAct = shadowAct[SH_PRD];

  // Up-counting time base
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (cmd.restart)   count <= PHASE_C;
    else if (stat.atPeriod) count <= '0;
    else                    count <= count + CNT_W'(1);
  end

  // Blanking window, one extra bit so offset + length cannot wrap
  logic [CNT_W:0] blankEnd;
  assign blankEnd = {1'b0, shadowAct[SH_OFF]} + {1'b0, shadowAct[SH_LEN]};

  always_comb begin
    stat.atZero   = (count == '0);
    stat.atPeriod = (count == shadowAct[SH_PRD]);
    stat.hitA     = (count == shadowAct[SH_CA]);
    stat.hitB     = (count == shadowAct[SH_CB]);
    stat.inBlank  = ({1'b0, count} >= {1'b0, shadowAct[SH_OFF]}) &&
                    ({1'b0, count} <  blankEnd);
  end

endmodule

// File: rtl/pcm_slave_control.sv
module pcm_slave_control
  import pcm_slave_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncIn,
  input  logic    compLevel,
  input  logic    modeSyncOnly,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    outA,
  output logic    outB,
  output logic    qualEvt
);

  // Two synchronizing flops plus one for edge detection
  logic [2:0] compPipe;
  logic       compRise;
  logic       eventDone;
  logic       tripHold;
  logic       newPeriod;
  logic [1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) compPipe <= '0;
    else       compPipe <= {compPipe[1:0], compLevel};
  end

  assign compRise  = compPipe[1] & ~compPipe[2];
  assign qualEvt   = compRise & ~stat.inBlank & ~eventDone;
  assign newPeriod = stat.atPeriod | syncIn;

  // One comparator event per period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          eventDone <= 1'b0;
    else if (qualEvt)   eventDone <= 1'b1;
    else if (newPeriod) eventDone <= 1'b0;
  end

  // Trip latch on output B, released at the next period start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         tripHold <= 1'b0;
    else if (qualEvt && !modeSyncOnly) tripHold <= 1'b1;
    else if (newPeriod)                tripHold <= 1'b0;
  end

  // Two mirrored legs: leg g sets on its own match, clears on the other
  assign hitVec = {stat.hitB, stat.hitA};

  for (genvar g = 0; g < 2; g++) begin : gLeg
    logic legQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        legQ <= 1'b0;
      else if (stat.atZero || stat.atPeriod || hitVec[1-g])
        legQ <= 1'b0;
      else if (hitVec[g])
        legQ <= 1'b1;
    end
  end

  assign outA = gLeg[0].legQ;
  assign outB = gLeg[1].legQ & ~tripHold;

  always_comb begin
    cmd.restart = syncIn | qualEvt;
    cmd.reload  = stat.atZero;
  end

endmodule

// File: rtl/pcm_slave_pwm.sv
module pcm_slave_pwm
  import pcm_slave_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PHASE_VAL  = 0,
  parameter int RST_PERIOD = 199,
  parameter int RST_CMPA   = RST_PERIOD + 10,
  parameter int RST_CMPB   = 20,
  parameter int RST_OFFSET = 2,
  parameter int RST_LENGTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             compLevel,
  input  logic             modeSyncOnly,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] cmpAIn,
  input  logic [CNT_W-1:0] cmpBIn,
  input  logic [CNT_W-1:0] blankOffset,
  input  logic [CNT_W-1:0] blankLength,
  output logic             outA,
  output logic             outB,
  output logic             syncOut
);

  dpCmd_t           dpCmd;
  dpStat_t          dpStat;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] periodAct;
  logic             qualEvt;

  assign syncOut = syncIn;

  pcm_slave_datapath #(
    .CNT_W(CNT_W), .PHASE_VAL(PHASE_VAL), .RST_PERIOD(RST_PERIOD),
    .RST_CMPA(RST_CMPA), .RST_CMPB(RST_CMPB),
    .RST_OFFSET(RST_OFFSET), .RST_LENGTH(RST_LENGTH)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(dpCmd),
    .periodIn(periodIn), .cmpAIn(cmpAIn), .cmpBIn(cmpBIn),
    .blankOffset(blankOffset), .blankLength(blankLength),
    .stat(dpStat), .count(count), .periodAct(periodAct)
  );

  pcm_slave_control i_control (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .compLevel(compLevel),
    .modeSyncOnly(modeSyncOnly), .stat(dpStat), .cmd(dpCmd),
    .outA(outA), .outB(outB), .qualEvt(qualEvt)
  );

endmodule

// File: rtl/pcm_slave_checker.sv
module pcm_slave_checker
  import pcm_slave_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PHASE_VAL = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeSyncOnly,
  input logic             outA,
  input logic             outB,
  input logic             qualEvt,
  input dpStat_t          stat,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] periodAct
);

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    count <= periodAct);

  a_r3_zero_clears_a: assert property (@(posedge clk) disable iff (!rstN)
    stat.atZero |=> !outA);

  a_r4_period_clears_b: assert property (@(posedge clk) disable iff (!rstN)
    stat.atPeriod |=> !outB);

  a_r6_period_held: assert property (@(posedge clk) disable iff (!rstN)
    !stat.atZero |=> $stable(periodAct));

  a_r9_event_restarts: assert property (@(posedge clk) disable iff (!rstN)
    qualEvt |=> (count == CNT_W'(PHASE_VAL)));

  a_r10_trip_forces_b: assert property (@(posedge clk) disable iff (!rstN)
    (qualEvt && !modeSyncOnly) |=> !outB);

endmodule

bind pcm_slave_pwm pcm_slave_checker #(.CNT_W(CNT_W), .PHASE_VAL(PHASE_VAL)) i_checker (
  .clk(clk), .rstN(rstN), .modeSyncOnly(modeSyncOnly), .outA(outA), .outB(outB),
  .qualEvt(qualEvt), .stat(dpStat), .count(count), .periodAct(periodAct)
);

// File: tb/test_pcm_slave_pwm.sv
module test_pcm_slave_pwm;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int RP         = 39;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         syncIn = 1'b0;
  logic         compLevel = 1'b0;
  logic         modeSyncOnly = 1'b0;
  logic [W-1:0] periodIn = W'(RP);
  logic [W-1:0] cmpAIn = W'(RP + 10);
  logic [W-1:0] cmpBIn = W'(20);
  logic [W-1:0] blankOffset = W'(2);
  logic [W-1:0] blankLength = W'(4);
  logic         outA, outB, syncOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_slave_pwm #(.CNT_W(W), .PHASE_VAL(0), .RST_PERIOD(RP)) i_pcm_slave_pwm (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .compLevel(compLevel),
    .modeSyncOnly(modeSyncOnly), .periodIn(periodIn), .cmpAIn(cmpAIn),
    .cmpBIn(cmpBIn), .blankOffset(blankOffset), .blankLength(blankLength),
    .outA(outA), .outB(outB), .syncOut(syncOut)
  );

  int checks = 0;
  int failures = 0;
  bit cmpEn = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  logic [W-1:0] mCnt, mPer, mCa, mCb, mOff, mLen, nCnt;
  logic [2:0]   mPipe;
  logic         mTrip, mDone, mA, mB;
  logic         atZ, atP, hA, hB, blank, rise, qual, newP, nA, nB, nTrip, nDone;

  function automatic logic legNext(input logic cur, input logic clr, input logic set);
    return clr ? 1'b0 : (set ? 1'b1 : cur);
  endfunction

  function automatic logic inWindow(input int c, input int o, input int l);
    return (c >= o) && (c < o + l);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = '0; mPer = W'(RP); mCa = W'(RP + 10); mCb = W'(20);
      mOff = W'(2); mLen = W'(4); mPipe = '0;
      mTrip = 1'b0; mDone = 1'b0; mA = 1'b0; mB = 1'b0;
    end else begin
      atZ   = (mCnt == 0);
      atP   = (mCnt == mPer);
      hA    = (mCnt == mCa);
      hB    = (mCnt == mCb);
      blank = inWindow(int'(mCnt), int'(mOff), int'(mLen));
      rise  = mPipe[1] && !mPipe[2];
      qual  = rise && !blank && !mDone;
      newP  = atP || syncIn;
      nA    = legNext(mA, atZ || atP || hB, hA);
      nB    = legNext(mB, atZ || atP || hA, hB);
      nTrip = (qual && !modeSyncOnly) ? 1'b1 : (newP ? 1'b0 : mTrip);
      nDone = qual ? 1'b1 : (newP ? 1'b0 : mDone);
      if (syncIn || qual) nCnt = '0;
      else if (atP)       nCnt = '0;
      else                nCnt = mCnt + W'(1);
      if (atZ) begin
        mPer = periodIn; mCa = cmpAIn; mCb = cmpBIn; mOff = blankOffset; mLen = blankLength;
      end
      mCnt = nCnt; mA = nA; mB = nB; mTrip = nTrip; mDone = nDone;
      mPipe = {mPipe[1:0], compLevel};
    end
  end

  // Per-cycle comparison, sampled away from the edge
  always @(posedge clk) begin
    #3;
    if (cmpEn) begin
      chk(outA === mA, "R3 outA vs model", int'(outA), int'(mA));
      chk(outB === (mB && !mTrip), "R4 outB vs model", int'(outB), int'(mB && !mTrip));
      chk(syncOut === syncIn, "R2 syncOut vs model", int'(syncOut), int'(syncIn));
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; returns at the negedge after the edge that saw syncIn
  task automatic syncPulse();
    syncIn = 1'b1;
    #1 chk(syncOut === 1'b1, "R2 sync pass high", int'(syncOut), 1);
    @(negedge clk);
    syncIn = 1'b0;
    #1 chk(syncOut === 1'b0, "R2 sync pass low", int'(syncOut), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitN(3);
    chk(outA === 1'b0, "R5 outA low in reset", int'(outA), 0);
    chk(outB === 1'b0, "R5 outB low in reset", int'(outB), 0);
    rstN = 1'b1;
    cmpEn = 1'b1;

    // R5: default compare A lies past the period and never sets A
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (outA !== 1'b0) chk(1'b0, "R5 default compare A never matches", int'(outA), 0);
    end
    chk(1'b1, "R5 default compare A never matches", 0, 0);

    cmpAIn = W'(5);
    cmpBIn = W'(10);
    waitN(50);

    // R6: compare B change mid-period waits for the next zero
    syncPulse();
    waitN(3);
    cmpBIn = W'(30);
    waitN(9);
    chk(outB === 1'b1, "R6 old compare B still active", int'(outB), 1);
    waitN(48);
    chk(outB === 1'b0, "R6 new compare B after reload", int'(outB), 0);
    cmpBIn = W'(10);
    waitN(50);

    // R7 R8 R1: edge evaluated at count 5, inside blanking, ignored
    syncPulse();
    waitN(3);
    compLevel = 1'b1;
    waitN(17);
    chk(outB === 1'b1, "R7 R8 R1 blanked edge leaves B running", int'(outB), 1);
    compLevel = 1'b0;
    waitN(5);

    // R10 R9: edge evaluated at count 6 trips B, A kept
    syncPulse();
    waitN(4);
    compLevel = 1'b1;
    waitN(3);
    chk(outA === 1'b1, "R10 A unchanged on trip", int'(outA), 1);
    waitN(20);
    chk(outB === 1'b0, "R9 R10 B held low after trip", int'(outB), 0);
    compLevel = 1'b0;
    waitN(4);
    syncPulse();
    waitN(15);
    chk(outB === 1'b1, "R10 trip released by sync", int'(outB), 1);
    waitN(5);

    // R11: sync-only mode, no output action
    modeSyncOnly = 1'b1;
    syncPulse();
    waitN(4);
    compLevel = 1'b1;
    waitN(23);
    chk(outB === 1'b1, "R11 B not tripped in sync-only mode", int'(outB), 1);
    compLevel = 1'b0;
    waitN(5);

    // R9 R12: restart observed through A, second edge in the period ignored
    syncPulse();
    waitN(4);
    compLevel = 1'b1;
    waitN(6);
    compLevel = 1'b0;
    waitN(4);
    chk(outA === 1'b1, "R9 counter restarted by event", int'(outA), 1);
    waitN(6);
    compLevel = 1'b1;
    waitN(11);
    chk(outA === 1'b0, "R12 second edge ignored", int'(outA), 0);
    compLevel = 1'b0;
    modeSyncOnly = 1'b0;
    waitN(5);

    // Random traffic checked against the model
    for (int it = 0; it < 300; it++) begin
      int per;
      per = 20 + int'($urandom_range(40));
      periodIn     = W'(per);
      cmpAIn       = W'($urandom_range(per + 15));
      cmpBIn       = W'($urandom_range(per + 15));
      blankOffset  = W'($urandom_range(10));
      blankLength  = W'($urandom_range(8));
      modeSyncOnly = 1'($urandom_range(1));
      for (int c = 0; c < 50; c++) begin
        @(negedge clk);
        if ($urandom_range(7) == 0) compLevel = ~compLevel;
        syncIn = ($urandom_range(59) == 0);
      end
    end
    syncIn = 1'b0;
    waitN(3);
    finishRun();
  end

endmodule